// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit operands and a carry-in, and returns a 16-bit sum and a carry-out. It has no clock and no state. The bits are split into four 4-bit groups. Inside each group, the carries come straight from per-bit generate and propagate terms. A second lookahead layer then combines each group's generate and propagate with the carry-in to form the carries into bits 4, 8 and 12 and the final carry-out. No carry ripples from one group to the next.

The block also drives a generate output and a propagate output that cover all 16 bits. With these, a wider adder can place this block under a further lookahead layer. Setting the carry-in to one adds one to the total. This is the step used to turn a one's complement into a two's complement.

Top module: `cla16_adder`

## Requirements
- R1: For any operands and carry-in, the 17-bit value {cout, sum} equals opa + opb + cin as unsigned integers.
- R2: When cin is 1, the result is exactly one more than with cin 0 for the same operands. opa = 16'hFFFF, opb = 0, cin = 1 gives sum 0 with cout 1. All-zero operands with cin = 1 give sum 1 with cout 0.
- R3: blk_p is 1 exactly when opa XOR opb is all ones, that is, when every bit position of the two operands differs.
- R4: blk_g is 1 exactly when opa + opb, without the carry-in, exceeds 16'hFFFF.
- R5: cout equals blk_g OR (blk_p AND cin) for every input.
- R6: blk_g and blk_p are never 1 at the same time.
- R7: The carry into bit 4k (k = 1, 2, 3) equals the carry out of the unsigned sum of the low 4k bits of both operands plus cin. A carry that enters at bit 0 therefore reaches bits 4, 8, 12 and 16 correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of bit 15 |
| blk_g | output | 1 | Generate term for all 16 bits |
| blk_p | output | 1 | Propagate term for all 16 bits |

## Verification
The main sweep runs every pair of byte values with both carry-in values. Each byte is repeated across both halves of the operands, so every group boundary sees every local carry situation. Random operands add mixed patterns in which the groups behave differently from one another. Directed cases target the carry chains. All ones plus one sends a carry through all sixteen bits. All-zero operands show that the carry-in alone reaches the sum. Operands such as 16'h0FFF plus one stop the carry at one specific group boundary, which separates a fault in the second-level carry terms from a fault in the in-group terms.

// File: rtl/cla16_adder.sv
module cla16_adder (
  input  logic [15:0] opa,
  input  logic [15:0] opb,
  input  logic        cin,
  output logic [15:0] sum,
  output logic        cout,
  output logic        blk_g,
  output logic        blk_p
);
  localparam int GW = 4;
  localparam int NG = 4;

  logic [15:0] g, p, c;
  logic [NG-1:0] gg, gp;
  logic [NG:0] gc;

  assign g = opa & opb;
  assign p = opa ^ opb;

  for (genvar k = 0; k < NG; k++) begin : g_grp
    localparam int B = k * GW;
    assign c[B]   = gc[k];
    assign c[B+1] = g[B] | (p[B] & gc[k]);
    assign c[B+2] = g[B+1] | (p[B+1] & g[B]) | (p[B+1] & p[B] & gc[k]);
    assign c[B+3] = g[B+2] | (p[B+2] & g[B+1]) | (p[B+2] & p[B+1] & g[B])
                  | (p[B+2] & p[B+1] & p[B] & gc[k]);
    assign gp[k]  = &p[B+3:B];
    assign gg[k]  = g[B+3] | (p[B+3] & g[B+2]) | (p[B+3] & p[B+2] & g[B+1])
                  | (p[B+3] & p[B+2] & p[B+1] & g[B]);
  end

  assign gc[0] = cin;
  assign gc[1] = gg[0] | (gp[0] & cin);
  assign gc[2] = gg[1] | (gp[1] & gg[0]) | (gp[1] & gp[0] & cin);
  assign gc[3] = gg[2] | (gp[2] & gg[1]) | (gp[2] & gp[1] & gg[0])
               | (gp[2] & gp[1] & gp[0] & cin);
  assign blk_g = gg[3] | (gp[3] & gg[2]) | (gp[3] & gp[2] & gg[1])
               | (gp[3] & gp[2] & gp[1] & gg[0]);
  assign blk_p = &gp;
  assign gc[4] = blk_g | (blk_p & cin);

  assign sum  = p ^ c;
  assign cout = gc[4];
endmodule

module cla16_adder_chk (
  input logic [15:0] opa,
  input logic [15:0] opb,
  input logic        cin,
  input logic [15:0] sum,
  input logic        cout,
  input logic        blk_g,
  input logic        blk_p,
  input logic [4:0]  gc
);
  logic [16:0] tot, nocin, msk, part;

  always_comb begin
    tot   = {1'b0, opa} + {1'b0, opb} + {16'b0, cin};
    nocin = {1'b0, opa} + {1'b0, opb};
    p_sum_r1: assert ({cout, sum} == tot) else $error("R1 sum mismatch");
    p_prop_r3: assert (blk_p == ((opa ^ opb) == 16'hFFFF)) else $error("R3 blk_p");
    p_gen_r4: assert (blk_g == nocin[16]) else $error("R4 blk_g");
    p_cout_r5: assert (cout == (blk_g | (blk_p & cin))) else $error("R5 cout");
    p_excl_r6: assert (!(blk_g && blk_p)) else $error("R6 g and p");
    for (int k = 1; k < 4; k++) begin
      msk  = (17'h1 << (4 * k)) - 17'h1;
      part = ({1'b0, opa} & msk) + ({1'b0, opb} & msk) + {16'b0, cin};
      p_grp_carry_r7: assert (gc[k] == part[4 * k]) else $error("R7 group carry");
    end
  end
endmodule

bind cla16_adder cla16_adder_chk u_chk (
  .opa(opa), .opb(opb), .cin(cin), .sum(sum), .cout(cout),
  .blk_g(blk_g), .blk_p(blk_p), .gc(gc)
);

// File: tb/cla16_adder_tb.sv
`timescale 1ns/1ps
module cla16_adder_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] opa = 16'h0;
  logic [15:0] opb = 16'h0;
  logic        cin = 1'b0;
  logic [15:0] sum;
  logic        cout, blk_g, blk_p;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  cla16_adder u_dut (
    .opa(opa), .opb(opb), .cin(cin),
    .sum(sum), .cout(cout), .blk_g(blk_g), .blk_p(blk_p)
  );

  task automatic expect1(input string tag, input logic [16:0] act, input logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h", tag, opa, opb, cin, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] a, input logic [15:0] b, input logic ci, input string tag);
    logic [16:0] tot, nc;
    opa = a; opb = b; cin = ci;
    #2;
    tot = {1'b0, a} + {1'b0, b} + {16'b0, ci};
    nc  = {1'b0, a} + {1'b0, b};
    expect1(tag, {cout, sum}, tot);
    expect1("R3", {16'b0, blk_p}, {16'b0, (a ^ b) == 16'hFFFF});
    expect1("R4", {16'b0, blk_g}, {16'b0, nc[16]});
    expect1("R5", {16'b0, cout}, {16'b0, blk_g | (blk_p & ci)});
    expect1("R6", {16'b0, blk_g & blk_p}, 17'h0);
    #1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // reset-state view: all-zero inputs, R1
    run(16'h0000, 16'h0000, 1'b0, "R1");
    // R2 corners
    run(16'hFFFF, 16'h0000, 1'b1, "R2");
    run(16'h0000, 16'h0000, 1'b1, "R2");
    run(16'hFFFF, 16'hFFFF, 1'b1, "R2");
    run(16'h1234, 16'h4321, 1'b1, "R2");
    // R7 carry stops at each group boundary
    run(16'h000F, 16'h0001, 1'b0, "R7");
    run(16'h00FF, 16'h0000, 1'b1, "R7");
    run(16'h0FFF, 16'h0001, 1'b0, "R7");
    run(16'h0FFF, 16'hF000, 1'b1, "R7");
    run(16'h8000, 16'h8000, 1'b0, "R7");
    run(16'h5555, 16'hAAAA, 1'b1, "R7");
    run(16'h5555, 16'hAAAA, 1'b0, "R3");
    // byte-pattern sweep, R1
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        for (int ci = 0; ci < 2; ci++)
          run({i[7:0], i[7:0]}, {j[7:0], j[7:0]}, ci[0], "R1");
    // random operands, R1
    for (int r = 0; r < 3000; r++)
      run(16'($urandom), 16'($urandom), 1'($urandom), "R1");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule